// File: doc/BRIEF.md
# NAND Command and Address Sequencer

This block drives the control side of a large-page NAND flash for one operation at a time. A host presents an opcode, a block number, a page number inside that block and a byte column offset, then pulses `start`. The sequencer first waits for the device to report ready. It then emits the command latch cycle and the column and row address latch cycles. Where the opcode needs one, it adds the confirm command, and it waits on ready/busy where the operation leaves the device busy. Completion is reported by a one-clock `done` pulse, with `error` raised beside it if a ready wait ran out of time.

Three opcodes are treated specially. An out-of-band read becomes an ordinary page read whose column points past the end of the main page area. A random-data-out request sends only the column and is closed by its own confirm. A device reset sends the command byte alone and then waits for ready. Parameters choose an 8-bit or 16-bit device bus and choose whether a third row byte is sent. Data transfer, error correction and bad-block handling belong to other blocks.

Top module: `nand_cmd_seq`

## Requirements
- R1: Out of reset and whenever idle, `ce_n`=1, `cle`=0, `ale`=0, `we_n`=1 and `done`=0.
- R2: After `start`, no write strobe is issued until `rb_ready` is 1; `we_n` stays high for as long as `rb_ready` is 0 before the command cycle.
- R3: `cle` and `ale` are never high in the same clock.
- R4: During a write strobe (`we_n` low) and at its rising edge, `io_out`, `cle` and `ale` hold steady.
- R5: Opcode 0x00 (page read) gives one command latch (`cle`=1) of 0x00, the address latches (`ale`=1), a command latch of 0x30, and then a wait for `rb_ready` before `done`.
- R6: Opcode 0x50 (out-of-band read) is sent as 0x00, with PAGE_BYTES (2048 by default) added to the column before any bus-width shift, and then behaves as in R5.
- R7: The row is page + block × 2^PG_W (64 pages per block by default). The address latches go out in this order: column[7:0], column[15:8], row[7:0], row[15:8].
- R8: With FIVE_CYC=1, one more address latch follows the row bytes, carrying {4'b0000, row[19:16]}.
- R9: Opcode 0x05 (random data out) sends the two column latches and no row latches. It is followed by a command latch of 0xE0, and `done` comes without any wait on `rb_ready`.
- R10: Opcode 0xFF (reset) sends only the command latch 0xFF, with no address latches, and then waits for `rb_ready` before `done`.
- R11: With BUS16=1 the column is shifted right by one bit, except for the byte-wide opcodes 0x90, 0xEC, 0xEE and 0xEF.
- R12: Each latch holds `we_n` low for exactly WE_CLKS clocks and then high for at least WE_CLKS clocks. Between a command phase and an address phase there is at least one clock with both `cle` and `ale` low.
- R13: If `rb_ready` stays low for TMO_CYCLES clocks in any ready wait, the operation ends with `done`=1 and `error`=1 in the same clock, and no further latch is issued.
- R14: `done` lasts one clock. A `start` that arrives while an operation is running is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| opcode | input | 8 | Requested NAND opcode |
| block_num | input | BLK_W | Erase block number |
| page_num | input | PG_W | Page number within the block |
| col_off | input | 16 | Byte column offset within the page |
| rb_ready | input | 1 | Device ready (1) / busy (0), synchronous to clk |
| done | output | 1 | One-clock completion pulse |
| error | output | 1 | Ready-wait timeout, valid with done |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| io_out | output | 8 | Command/address byte to the device |

## Verification
The main sequence is driven from a table of operations that covers a plain read, an out-of-band read, random data out, a generic command with a row above 16 bits, a byte-wide opcode, and all-ones fields. Each row runs at once on an 8-bit/four-address instance and on a 16-bit/five-address instance. Comparing the two sets of latched bytes separates the column shift and its byte-wide exceptions from the extra row byte and the out-of-band offset. Directed runs hold ready low before the command, drop it after each confirm byte (0x30, 0xFF and 0xE0), and hold it past the time limit. These runs show which operations really wait and that the timeout aborts. A second start pulse during a run shows that it is ignored.

// File: rtl/nand_seq_pkg.sv
// Package: shared opcode constants, operation kinds and sequencer states
// for the NAND command/address sequencer.
package nand_seq_pkg;

    localparam logic [7:0] OP_PAGE_READ = 8'h00;
    localparam logic [7:0] OP_SPARE_RD  = 8'h50;
    localparam logic [7:0] OP_RAND_OUT  = 8'h05;
    localparam logic [7:0] OP_DEV_RST   = 8'hFF;
    localparam logic [7:0] CF_READ_GO   = 8'h30;
    localparam logic [7:0] CF_RAND_GO   = 8'hE0;

    typedef enum logic [1:0] {
        K_PLAIN,
        K_READ,
        K_RANDOUT,
        K_RESET
    } op_kind_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WPRE,
        S_CMD,
        S_ADDR,
        S_CONF,
        S_GAP,
        S_WPOST,
        S_DONE
    } seq_state_t;

    // Opcodes whose column is always byte addressed, even on a 16-bit bus.
    function automatic logic byte_wide_op(input logic [7:0] op);
        return (op == 8'h90) || (op == 8'hEC) || (op == 8'hEE) || (op == 8'hEF);
    endfunction

endpackage

// File: rtl/nand_addr_gen.sv
// Module: nand_addr_gen
// Turns a captured request into the effective command byte, the operation
// kind, the confirm byte and the list of address bytes to send.
// Assumes the inputs are held stable for the whole operation.
module nand_addr_gen
    import nand_seq_pkg::*;
#(
    parameter int BLK_W      = 12,
    parameter int PG_W       = 6,
    parameter int PAGE_BYTES = 2048,
    parameter bit BUS16      = 1'b0,
    parameter bit FIVE_CYC   = 1'b0
) (
    input  logic [7:0]       op,
    input  logic [BLK_W-1:0] blk,
    input  logic [PG_W-1:0]  pg,
    input  logic [15:0]      col,
    output logic [7:0]       cmd_byte,
    output logic [7:0]       conf_byte,
    output op_kind_t         kind,
    output logic [4:0][7:0]  addr_bytes,
    output logic [2:0]       n_addr
);

    localparam int ROW_W       = 20;
    localparam int PAGES_PER   = 1 << PG_W;
    localparam int N_ROW_BYTES = FIVE_CYC ? 3 : 2;

    logic              spare;
    logic [15:0]       col_adj;
    logic [15:0]       col_bus;
    logic [ROW_W-1:0]  row;

    // Classify the opcode and choose the effective command and confirm.
    always_comb begin
        spare     = (op == OP_SPARE_RD);
        cmd_byte  = spare ? OP_PAGE_READ : op;
        conf_byte = 8'h00;
        if (cmd_byte == OP_PAGE_READ) begin
            kind      = K_READ;
            conf_byte = CF_READ_GO;
        end else if (cmd_byte == OP_RAND_OUT) begin
            kind      = K_RANDOUT;
            conf_byte = CF_RAND_GO;
        end else if (cmd_byte == OP_DEV_RST) begin
            kind      = K_RESET;
        end else begin
            kind      = K_PLAIN;
        end
    end

    // Spare-area reads point past the main page before any width shift.
    assign col_adj = spare ? (col + 16'(PAGE_BYTES)) : col;

    generate
        if (BUS16) begin : g_wide
            // Word addressing on a 16-bit bus, except byte-wide opcodes.
            assign col_bus = byte_wide_op(cmd_byte) ? col_adj : {1'b0, col_adj[15:1]};
        end else begin : g_narrow
            assign col_bus = col_adj;
        end
    endgenerate

    // Linear page row inside the device.
    assign row = ROW_W'(pg) + ROW_W'(blk) * ROW_W'(PAGES_PER);

    // Address byte list in transmit order and its length.
    always_comb begin
        addr_bytes[0] = col_bus[7:0];
        addr_bytes[1] = col_bus[15:8];
        addr_bytes[2] = row[7:0];
        addr_bytes[3] = row[15:8];
        addr_bytes[4] = {4'h0, row[19:16]};
        n_addr = (kind == K_RANDOUT) ? 3'd2 : 3'(2 + N_ROW_BYTES);
    end

endmodule

// File: rtl/nand_phase_timer.sv
// Module: nand_phase_timer
// Counts the clocks of one bus phase: a latch phase (strobe low for
// WE_CLKS, then high for WE_CLKS) or a release gap (WE_CLKS clocks).
// Assumes run stays high for the whole phase; last marks its final clock.
module nand_phase_timer #(
    parameter int WE_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic long_ph,
    output logic strobe_low,
    output logic last
);

    localparam int CW = $clog2(2 * WE_CLKS) + 1;

    logic [CW-1:0] cnt;

    assign last       = run && (long_ph ? (cnt == CW'(2 * WE_CLKS - 1))
                                        : (cnt == CW'(WE_CLKS - 1)));
    assign strobe_low = run && long_ph && (cnt < CW'(WE_CLKS));

    // Phase clock counter, restarting at the end of every phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || last) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/nand_rb_wait.sv
// Module: nand_rb_wait
// Watches the ready/busy input during a wait and flags ready or expiry
// after TMO_CYCLES busy clocks. Assumes rb_ready is synchronous to clk.
module nand_rb_wait #(
    parameter int TMO_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic rb_ready,
    output logic ok,
    output logic expired
);

    localparam int TW = $clog2(TMO_CYCLES) + 1;

    logic [TW-1:0] cnt;

    assign ok      = active && rb_ready;
    assign expired = active && !rb_ready && (cnt == TW'(TMO_CYCLES - 1));

    // Busy-clock counter, cleared outside a wait or once ready.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || rb_ready || expired) cnt <= '0;
        else                                          cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/nand_cmd_seq.sv
// Module: nand_cmd_seq (top)
// Issues one NAND command with its address and confirm cycles, waiting
// on ready/busy where needed, and signals done (and error on timeout).
// Assumes rb_ready is already synchronous; all pins are registered.
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter int BLK_W      = 12,
    parameter int PG_W       = 6,
    parameter int PAGE_BYTES = 2048,
    parameter bit BUS16      = 1'b0,
    parameter bit FIVE_CYC   = 1'b0,
    parameter int WE_CLKS    = 2,
    parameter int TMO_CYCLES = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       opcode,
    input  logic [BLK_W-1:0] block_num,
    input  logic [PG_W-1:0]  page_num,
    input  logic [15:0]      col_off,
    input  logic             rb_ready,
    output logic             done,
    output logic             error,
    output logic             ce_n,
    output logic             cle,
    output logic             ale,
    output logic             we_n,
    output logic [7:0]       io_out
);

    seq_state_t       state, after_st;
    logic [2:0]       idx;
    logic [7:0]       op_q;
    logic [BLK_W-1:0] blk_q;
    logic [PG_W-1:0]  pg_q;
    logic [15:0]      col_q;
    logic             err_q;

    logic [7:0]       cmd_byte, conf_byte;
    op_kind_t         kind;
    logic [4:0][7:0]  addr_bytes;
    logic [2:0]       n_addr;
    logic             run, long_ph, strobe_low, ph_last;
    logic             wait_on, rdy_ok, rdy_tmo;

    nand_addr_gen #(
        .BLK_W(BLK_W), .PG_W(PG_W), .PAGE_BYTES(PAGE_BYTES),
        .BUS16(BUS16), .FIVE_CYC(FIVE_CYC)
    ) u_addr (
        .op(op_q), .blk(blk_q), .pg(pg_q), .col(col_q),
        .cmd_byte(cmd_byte), .conf_byte(conf_byte), .kind(kind),
        .addr_bytes(addr_bytes), .n_addr(n_addr)
    );

    assign run     = (state == S_CMD) || (state == S_ADDR) ||
                     (state == S_CONF) || (state == S_GAP);
    assign long_ph = (state != S_GAP);
    assign wait_on = (state == S_WPRE) || (state == S_WPOST);

    nand_phase_timer #(.WE_CLKS(WE_CLKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .long_ph(long_ph),
        .strobe_low(strobe_low), .last(ph_last)
    );

    nand_rb_wait #(.TMO_CYCLES(TMO_CYCLES)) u_wait (
        .clk(clk), .rst_n(rst_n), .active(wait_on), .rb_ready(rb_ready),
        .ok(rdy_ok), .expired(rdy_tmo)
    );

    // Operation sequencing: capture, waits, latch phases and gaps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            after_st <= S_IDLE;
            idx      <= '0;
            op_q     <= '0;
            blk_q    <= '0;
            pg_q     <= '0;
            col_q    <= '0;
            err_q    <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    op_q  <= opcode;
                    blk_q <= block_num;
                    pg_q  <= page_num;
                    col_q <= col_off;
                    err_q <= 1'b0;
                    state <= S_WPRE;
                end
                S_WPRE: begin
                    if (rdy_ok) state <= S_CMD;
                    else if (rdy_tmo) begin
                        err_q <= 1'b1;
                        state <= S_DONE;
                    end
                end
                S_CMD: if (ph_last) begin
                    idx      <= '0;
                    state    <= S_GAP;
                    after_st <= (kind == K_RESET) ? S_WPOST : S_ADDR;
                end
                S_ADDR: if (ph_last) begin
                    if (idx == n_addr - 3'd1) begin
                        state    <= S_GAP;
                        after_st <= (kind == K_READ || kind == K_RANDOUT) ? S_CONF : S_DONE;
                    end else begin
                        idx <= idx + 3'd1;
                    end
                end
                S_CONF: if (ph_last) begin
                    state    <= S_GAP;
                    after_st <= (kind == K_READ) ? S_WPOST : S_DONE;
                end
                S_GAP: if (ph_last) state <= after_st;
                S_WPOST: begin
                    if (rdy_ok) state <= S_DONE;
                    else if (rdy_tmo) begin
                        err_q <= 1'b1;
                        state <= S_DONE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Registered pin drive derived from the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n   <= 1'b1;
            cle    <= 1'b0;
            ale    <= 1'b0;
            we_n   <= 1'b1;
            io_out <= 8'h00;
            done   <= 1'b0;
            error  <= 1'b0;
        end else begin
            ce_n  <= (state == S_IDLE);
            cle   <= (state == S_CMD) || (state == S_CONF);
            ale   <= (state == S_ADDR);
            we_n  <= !strobe_low;
            done  <= (state == S_DONE);
            error <= (state == S_DONE) && err_q;
            case (state)
                S_CMD:   io_out <= cmd_byte;
                S_ADDR:  io_out <= addr_bytes[idx];
                S_CONF:  io_out <= conf_byte;
                default: io_out <= 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/nand_cmd_seq_chk.sv
// Module: nand_cmd_seq_chk
// Protocol checker for the sequencer pins; bound into every instance.
// Assumes synchronous active-low reset is held from time zero.
module nand_cmd_seq_chk #(
    parameter int WE_CLKS = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       done,
    input logic       error,
    input logic       ce_n,
    input logic       cle,
    input logic       ale,
    input logic       we_n,
    input logic [7:0] io_out
);

    logic [7:0] lo_cnt;

    // Length of the current run of low write-strobe clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)                 lo_cnt <= '0;
        else if (!we_n && lo_cnt != 8'hFF) lo_cnt <= lo_cnt + 8'd1;
        else if (we_n)              lo_cnt <= '0;
    end

    a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> (!cle && !ale && we_n));

    a_r3_cle_ale_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));

    a_r4_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(we_n) |-> ($stable(io_out) && $stable(cle) && $stable(ale)));

    a_r12_we_low_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (lo_cnt == 8'(WE_CLKS)));

    a_r12_we_low_max: assert property (@(posedge clk) disable iff (!rst_n)
        lo_cnt <= 8'(WE_CLKS));

    a_r13_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);

    a_r14_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind nand_cmd_seq nand_cmd_seq_chk #(.WE_CLKS(WE_CLKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .done(done), .error(error), .ce_n(ce_n),
    .cle(cle), .ale(ale), .we_n(we_n), .io_out(io_out)
);

// File: tb/nand_cmd_seq_tb_top.sv
// Bench: two sequencer instances (8-bit/4-address and 16-bit/5-address)
// driven in parallel; latched bytes are captured at each strobe rise.
module nand_cmd_seq_tb_top;

    localparam int WE_CLKS = 2;
    localparam int TMO     = 200;
    localparam int NV      = 6;

    // {opcode, block, page, column}
    localparam logic [41:0] VEC [NV] = '{
        {8'h00, 12'd3,    6'd5,  16'h0123},
        {8'h50, 12'd1,    6'd0,  16'h0000},
        {8'h05, 12'd0,    6'd0,  16'h0456},
        {8'h80, 12'd3000, 6'd17, 16'h07FF},
        {8'h90, 12'd7,    6'd2,  16'h0021},
        {8'h00, 12'd4095, 6'd63, 16'hFFFF}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ext_rb = 1'b1;
    logic [7:0] op_i = 8'h00;
    logic [11:0] blk_i = '0;
    logic [5:0] pg_i = '0;
    logic [15:0] col_i = '0;
    logic [1:0] rb_w, done_w, err_w, ce_n_w, cle_w, ale_w, we_n_w;
    logic [7:0] io_w [2];

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [9:0] cap [2][16];
    logic [9:0] expv [2][16];
    int cap_n [2], exp_n [2], done_cnt [2], busy_cnt [2], fall_cnt [2];
    int trig_cnt [2], lo_run [2], hi_run [2], bad_strobe [2], bad_gap [2];
    bit prev_we [2], done_busy [2], last_err [2], gap_seen [2];
    logic [1:0] last_kind [2];
    bit auto_busy = 1'b1, e0_busy = 1'b0;
    int busy_len = 20;

    always #10 clk = ~clk;

    assign rb_w[0] = ext_rb && (busy_cnt[0] == 0);
    assign rb_w[1] = ext_rb && (busy_cnt[1] == 0);

    nand_cmd_seq #(.BLK_W(12), .PG_W(6), .WE_CLKS(WE_CLKS), .TMO_CYCLES(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(op_i), .block_num(blk_i),
        .page_num(pg_i), .col_off(col_i), .rb_ready(rb_w[0]), .done(done_w[0]),
        .error(err_w[0]), .ce_n(ce_n_w[0]), .cle(cle_w[0]), .ale(ale_w[0]),
        .we_n(we_n_w[0]), .io_out(io_w[0]));

    nand_cmd_seq #(.BLK_W(12), .PG_W(6), .BUS16(1'b1), .FIVE_CYC(1'b1),
                   .WE_CLKS(WE_CLKS), .TMO_CYCLES(TMO)) dut16_i (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(op_i), .block_num(blk_i),
        .page_num(pg_i), .col_off(col_i), .rb_ready(rb_w[1]), .done(done_w[1]),
        .error(err_w[1]), .ce_n(ce_n_w[1]), .cle(cle_w[1]), .ale(ale_w[1]),
        .we_n(we_n_w[1]), .io_out(io_w[1]));

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // Pin monitor: strobe capture, busy model, strobe/gap timing, done.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "WDOG", "watchdog expired", cyc, 150000);
            finish_run();
        end
        for (int d = 0; d < 2; d++) begin
            if (busy_cnt[d] > 0) busy_cnt[d]--;
            if (!rst_n) begin
                prev_we[d] = 1'b1; hi_run[d] = 99; lo_run[d] = 0;
            end else begin
                if (!cle_w[d] && !ale_w[d]) gap_seen[d] = 1'b1;
                if (prev_we[d] && !we_n_w[d]) begin
                    fall_cnt[d]++;
                    if (hi_run[d] < WE_CLKS) bad_strobe[d]++;
                    lo_run[d] = 0;
                end
                if (!we_n_w[d]) lo_run[d]++; else hi_run[d]++;
                if (!prev_we[d] && we_n_w[d]) begin
                    if (lo_run[d] != WE_CLKS) bad_strobe[d]++;
                    hi_run[d] = 1;
                    if (cap_n[d] > 0 && last_kind[d] != {cle_w[d], ale_w[d]} && !gap_seen[d])
                        bad_gap[d]++;
                    last_kind[d] = {cle_w[d], ale_w[d]};
                    gap_seen[d] = 1'b0;
                    if (cap_n[d] < 16) cap[d][cap_n[d]] = {cle_w[d], ale_w[d], io_w[d]};
                    cap_n[d]++;
                    if (cle_w[d] && auto_busy && (io_w[d] == 8'h30 || io_w[d] == 8'hFF)) begin
                        busy_cnt[d] = busy_len; trig_cnt[d]++;
                    end
                    if (cle_w[d] && e0_busy && io_w[d] == 8'hE0) begin
                        busy_cnt[d] = busy_len; trig_cnt[d]++;
                    end
                end
                if (done_w[d]) begin
                    done_cnt[d]++;
                    last_err[d] = err_w[d];
                    if (busy_cnt[d] != 0 || !ext_rb) done_busy[d] = 1'b1;
                end
                prev_we[d] = we_n_w[d];
            end
        end
    end

    task automatic push(input int d, input logic [9:0] v);
        expv[d][exp_n[d]] = v;
        exp_n[d]++;
    endtask

    // Expected latch list from the requirements (d=1: 16-bit, 5 addresses).
    task automatic build_exp(input int d, input logic [7:0] op, input logic [11:0] b,
                             input logic [5:0] p, input logic [15:0] c);
        logic [7:0] cm;
        logic [15:0] cc;
        logic [19:0] rw;
        exp_n[d] = 0;
        cm = (op == 8'h50) ? 8'h00 : op;
        cc = (op == 8'h50) ? c + 16'd2048 : c;
        if (d == 1 && !(cm == 8'h90 || cm == 8'hEC || cm == 8'hEE || cm == 8'hEF))
            cc = cc >> 1;
        push(d, {2'b10, cm});
        if (cm != 8'hFF) begin
            push(d, {2'b01, cc[7:0]});
            push(d, {2'b01, cc[15:8]});
            if (cm != 8'h05) begin
                rw = 20'(b) * 20'd64 + 20'(p);
                push(d, {2'b01, rw[7:0]});
                push(d, {2'b01, rw[15:8]});
                if (d == 1) push(d, {2'b01, 4'h0, rw[19:16]});
            end
            if (cm == 8'h00) push(d, {2'b10, 8'h30});
            if (cm == 8'h05) push(d, {2'b10, 8'hE0});
        end
    endtask

    task automatic clear_caps();
        for (int d = 0; d < 2; d++) begin
            cap_n[d] = 0; done_busy[d] = 1'b0; gap_seen[d] = 1'b0;
        end
    endtask

    task automatic compare_seq(input int d, input string tag);
        chk(cap_n[d] == exp_n[d], tag, $sformatf("dut%0d latch count", d), cap_n[d], exp_n[d]);
        for (int i = 0; i < exp_n[d] && i < cap_n[d] && i < 16; i++)
            chk(cap[d][i] == expv[d][i], tag, $sformatf("dut%0d latch %0d {cle,ale,io}", d, i),
                int'(cap[d][i]), int'(expv[d][i]));
    endtask

    task automatic pulse_start(input logic [7:0] op, input logic [11:0] b,
                               input logic [5:0] p, input logic [15:0] c);
        @(negedge clk);
        op_i = op; blk_i = b; pg_i = p; col_i = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input int b0, input int b1);
        while (done_cnt[0] == b0 || done_cnt[1] == b1) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_op(input logic [7:0] op, input logic [11:0] b,
                          input logic [5:0] p, input logic [15:0] c);
        int b0, b1;
        b0 = done_cnt[0]; b1 = done_cnt[1];
        clear_caps();
        pulse_start(op, b, p, c);
        wait_done(b0, b1);
        build_exp(0, op, b, p, c);
        build_exp(1, op, b, p, c);
    endtask

    function automatic string tag_of(input logic [7:0] op, input int d);
        string t;
        case (op)
            8'h00:   t = "R5/R7";
            8'h50:   t = "R6";
            8'h05:   t = "R9";
            8'h90:   t = "R11";
            default: t = "R7";
        endcase
        if (d == 1) t = {t, "/R8/R11"};
        return t;
    endfunction

    initial begin
        for (int d = 0; d < 2; d++) begin
            cap_n[d] = 0; exp_n[d] = 0; done_cnt[d] = 0; busy_cnt[d] = 0; fall_cnt[d] = 0;
            trig_cnt[d] = 0; lo_run[d] = 0; hi_run[d] = 99; bad_strobe[d] = 0; bad_gap[d] = 0;
            prev_we[d] = 1'b1; last_kind[d] = 2'b00;
        end
        repeat (4) @(negedge clk);
        // R1: reset state
        for (int d = 0; d < 2; d++)
            chk({ce_n_w[d], cle_w[d], ale_w[d], we_n_w[d], done_w[d]} == 5'b10010, "R1",
                $sformatf("dut%0d reset pins", d),
                int'({ce_n_w[d], cle_w[d], ale_w[d], we_n_w[d], done_w[d]}), 5'b10010);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Table walk: main sequences on both bus configurations
        for (int v = 0; v < NV; v++) begin
            run_op(VEC[v][41:34], VEC[v][33:22], VEC[v][21:16], VEC[v][15:0]);
            for (int d = 0; d < 2; d++) begin
                compare_seq(d, tag_of(VEC[v][41:34], d));
                chk(last_err[d] == 1'b0, "R13", $sformatf("dut%0d no error", d), last_err[d], 0);
            end
        end

        // R5: page read waits for ready after the 0x30 confirm
        begin
            int t0 [2];
            t0[0] = trig_cnt[0]; t0[1] = trig_cnt[1];
            run_op(8'h00, 12'd9, 6'd1, 16'h0010);
            for (int d = 0; d < 2; d++) begin
                chk(trig_cnt[d] == t0[d] + 1, "R5", $sformatf("dut%0d busy after 0x30", d), trig_cnt[d], t0[d] + 1);
                chk(done_busy[d] == 1'b0, "R5", $sformatf("dut%0d done while busy", d), done_busy[d], 0);
            end
        end

        // R10: reset opcode is a lone command followed by a ready wait
        run_op(8'hFF, 12'd5, 6'd5, 16'h1234);
        for (int d = 0; d < 2; d++) begin
            compare_seq(d, "R10");
            chk(done_busy[d] == 1'b0, "R10", $sformatf("dut%0d done while busy", d), done_busy[d], 0);
        end

        // R9: random data out does not wait after 0xE0
        e0_busy = 1'b1;
        run_op(8'h05, 12'd0, 6'd0, 16'h0200);
        for (int d = 0; d < 2; d++) begin
            compare_seq(d, "R9");
            chk(done_busy[d] == 1'b1, "R9", $sformatf("dut%0d done during busy", d), done_busy[d], 1);
        end
        e0_busy = 1'b0;
        repeat (busy_len + 2) @(negedge clk);

        // R2: no strobe while ready is low before the command
        begin
            int f0 [2], b0, b1;
            f0[0] = fall_cnt[0]; f0[1] = fall_cnt[1];
            b0 = done_cnt[0]; b1 = done_cnt[1];
            ext_rb = 1'b0;
            clear_caps();
            pulse_start(8'h80, 12'd2, 6'd3, 16'h0004);
            repeat (40) @(negedge clk);
            for (int d = 0; d < 2; d++)
                chk(fall_cnt[d] == f0[d], "R2", $sformatf("dut%0d strobes while busy", d), fall_cnt[d] - f0[d], 0);
            ext_rb = 1'b1;
            wait_done(b0, b1);
            build_exp(0, 8'h80, 12'd2, 6'd3, 16'h0004);
            build_exp(1, 8'h80, 12'd2, 6'd3, 16'h0004);
            for (int d = 0; d < 2; d++) compare_seq(d, "R2");
        end

        // R13: timeout before the command
        begin
            int c0;
            ext_rb = 1'b0;
            c0 = cyc;
            run_op(8'h00, 12'd1, 6'd1, 16'h0001);
            for (int d = 0; d < 2; d++) begin
                chk(last_err[d] == 1'b1, "R13", $sformatf("dut%0d error flag", d), last_err[d], 1);
                chk(cap_n[d] == 0, "R13", $sformatf("dut%0d latches after timeout", d), cap_n[d], 0);
            end
            chk(cyc - c0 >= TMO, "R13", "timeout duration", cyc - c0, TMO);
            ext_rb = 1'b1;
        end

        // R13: timeout in the wait after the read confirm
        busy_len = 1000;
        run_op(8'h00, 12'd6, 6'd6, 16'h0066);
        for (int d = 0; d < 2; d++) begin
            compare_seq(d, "R13");
            chk(last_err[d] == 1'b1, "R13", $sformatf("dut%0d post-wait error", d), last_err[d], 1);
        end
        busy_cnt[0] = 0; busy_cnt[1] = 0;
        busy_len = 20;
        repeat (3) @(negedge clk);

        // R14: a start during a running operation is ignored
        begin
            int b0, b1;
            b0 = done_cnt[0]; b1 = done_cnt[1];
            clear_caps();
            pulse_start(8'h80, 12'd11, 6'd12, 16'h0013);
            repeat (6) @(negedge clk);
            pulse_start(8'hFF, 12'd0, 6'd0, 16'h0000);
            wait_done(b0, b1);
            repeat (100) @(negedge clk);
            build_exp(0, 8'h80, 12'd11, 6'd12, 16'h0013);
            build_exp(1, 8'h80, 12'd11, 6'd12, 16'h0013);
            for (int d = 0; d < 2; d++) begin
                compare_seq(d, "R14");
                chk(done_cnt[d] == b0 + 1 - (d == 1 ? b0 - b1 : 0), "R14",
                    $sformatf("dut%0d done count", d), done_cnt[d], (d == 0 ? b0 : b1) + 1);
            end
        end

        // R12 / R3 / R4: strobe widths and phase gaps over the whole run
        for (int d = 0; d < 2; d++) begin
            chk(bad_strobe[d] == 0, "R12", $sformatf("dut%0d strobe timing faults", d), bad_strobe[d], 0);
            chk(bad_gap[d] == 0, "R12", $sformatf("dut%0d missing phase gaps", d), bad_gap[d], 0);
        end

        // R1: reset in the middle of an operation returns pins to idle
        pulse_start(8'h00, 12'd1, 6'd2, 16'h0003);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int d = 0; d < 2; d++)
            chk({ce_n_w[d], cle_w[d], ale_w[d], we_n_w[d]} == 4'b1001, "R1",
                $sformatf("dut%0d pins after mid-run reset", d),
                int'({ce_n_w[d], cle_w[d], ale_w[d], we_n_w[d]}), 4'b1001);
        finish_run();
    end

endmodule